// File: doc/BRIEF.md
# Multi-Lane Bit-Striping Transfer Sequencer

This block sits between a byte-wide transmit queue, a set of parallel serial lane engines and a byte-wide receive queue. Each time it is told to flush, it works through the transmit queue one group at a time. In striped mode a group is one byte per lane. Those bytes are interleaved bit by bit across the lanes before they go out. The bytes that come back are de-interleaved and all of them are written to the receive queue. In replicated mode a group is a single byte. That byte goes out on every lane, and only the byte returned by lane 0 is kept.

The lanes are plain byte-exchange handshakes: a one-cycle request with a byte, and later a one-cycle done with the returned byte. The sequencer decides the mode again at the start of every group. It keeps looping until the queue no longer holds a whole group. It keeps two sticky error flags, one for running out of transmit data and one for a full receive queue. Running out of transmit data is not an error while a memory-mapped (linear) access mode is active.

Top module: `lane_stripe_seq`

## Requirements
- R1: After reset, tx_pop_o, rx_push_o, lane_req_o and busy_o are all 0 and both sticky flags read 0.
- R2: In striped mode (striped_mode_i=1) a group pops LANES bytes, element 0 first. Bit q of the lane bus (lane q/8, bit q%8) carries bit q/LANES of popped element q%LANES.
- R3: In striped mode the returned lane bytes are de-interleaved by the inverse of the R2 mapping. All LANES resulting bytes are pushed, element 0 first.
- R4: In replicated mode (striped_mode_i=0) a group pops exactly one byte and drives that same byte on every lane.
- R5: In replicated mode exactly one byte is pushed per group, and it is the byte returned by lane 0.
- R6: A group starts only if tx_level_i is at least LANES (striped) or at least 1 (replicated). A partial striped group is left in the queue untouched.
- R7: When a flush finds too little data for a group, the sequencer returns to idle. tx_underflow_o becomes 1 if linear_mode_i is 0 and stays unchanged if it is 1.
- R8: A push that falls while rx_full_i is 1 is dropped: rx_push_o stays 0 and rx_overflow_o becomes 1.
- R9: Both flags hold until clr_flags_i is 1. If a flag is set and cleared in the same cycle, the set wins.
- R10: All lane requests are raised together for exactly one cycle. No push happens until every lane has reported done for that group.
- R11: After each group the sequencer checks the queue again. It keeps running groups, each taking the mode present at its start, until too little data remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Pulse that starts draining the transmit queue |
| striped_mode_i | input | 1 | 1 = bit-striped groups, 0 = replicated single byte |
| linear_mode_i | input | 1 | 1 suppresses the underflow flag |
| clr_flags_i | input | 1 | Clears both sticky flags |
| tx_level_i | input | LVL_W | Bytes held in the transmit queue |
| tx_data_i | input | BYTE_W | Head byte of the transmit queue (show-ahead) |
| tx_pop_o | output | 1 | Removes the head byte of the transmit queue |
| rx_full_i | input | 1 | Receive queue cannot accept a byte |
| rx_push_o | output | 1 | Writes rx_data_o into the receive queue |
| rx_data_o | output | BYTE_W | Byte being pushed |
| lane_req_o | output | LANES | Per-lane transfer request pulse |
| lane_tx_o | output | LANES*BYTE_W | Byte sent on each lane, lane j at bits j*BYTE_W |
| lane_done_i | input | LANES | Per-lane completion pulse |
| lane_rx_i | input | LANES*BYTE_W | Byte returned by each lane, valid with its done |
| busy_o | output | 1 | Sequencer is not idle |
| tx_underflow_o | output | 1 | Sticky transmit-underflow flag |
| rx_overflow_o | output | 1 | Sticky receive-overflow flag |

## Verification
Setting a sticky flag and clearing it can land on the same clock edge. The bench provokes this by holding clr_flags_i high for a whole striped group while rx_full_i is also high, so that both drops of the group meet an active clear. It judges the result by watching rx_overflow_o between cycles. The flag must be seen high during the group, which shows the set won, and it must return to 0 once the group has finished and the clear is still held.

// File: rtl/lss_pkg.sv
package lss_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_POP,
      ST_LAUNCH,
      ST_WAIT,
      ST_PUSH
   } seq_state_e;

endpackage

// File: rtl/lss_stripe_net.sv
// Pure wiring permutation between element-major bytes and a bit-interleaved
// lane bus. INVERSE selects which side the interleaved form is on.
module lss_stripe_net #(
   parameter int LANES   = 2,
   parameter int BYTE_W  = 8,
   parameter bit INVERSE = 1'b0
) (
   input  logic [LANES*BYTE_W-1:0] din,
   output logic [LANES*BYTE_W-1:0] dout
);
   localparam int TOTAL = LANES * BYTE_W;

   for (genvar q = 0; q < TOTAL; q++) begin : g_bit
      localparam int ELEM_POS = (q % LANES) * BYTE_W + (q / LANES);
      if (INVERSE) begin : g_inv
         assign dout[ELEM_POS] = din[q];
      end else begin : g_fwd
         assign dout[q] = din[ELEM_POS];
      end
   end

endmodule

// File: rtl/lss_tx_gather.sv
module lss_tx_gather #(
   parameter int LANES  = 2,
   parameter int BYTE_W = 8,
   parameter int IDX_W  = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_i,
   input  logic [IDX_W-1:0]         wr_idx_i,
   input  logic [BYTE_W-1:0]        data_i,
   input  logic                     striped_i,
   output logic [LANES*BYTE_W-1:0]  lane_tx_o
);
   logic [LANES*BYTE_W-1:0] elem_q;
   logic [LANES*BYTE_W-1:0] interleaved;

   for (genvar j = 0; j < LANES; j++) begin : g_elem
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            elem_q[j*BYTE_W +: BYTE_W] <= '0;
         end else if (wr_i && (wr_idx_i == IDX_W'(j))) begin
            elem_q[j*BYTE_W +: BYTE_W] <= data_i;
         end
      end
   end

   lss_stripe_net #(
      .LANES  (LANES),
      .BYTE_W (BYTE_W),
      .INVERSE(1'b0)
   ) u_fwd (
      .din (elem_q),
      .dout(interleaved)
   );

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      assign lane_tx_o[j*BYTE_W +: BYTE_W] =
         striped_i ? interleaved[j*BYTE_W +: BYTE_W] : elem_q[BYTE_W-1:0];
   end

endmodule

// File: rtl/lss_rx_collect.sv
module lss_rx_collect #(
   parameter int LANES  = 2,
   parameter int BYTE_W = 8,
   parameter int IDX_W  = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     arm_i,
   input  logic [LANES-1:0]         lane_done_i,
   input  logic [LANES*BYTE_W-1:0]  lane_rx_i,
   input  logic                     striped_i,
   input  logic [IDX_W-1:0]         rd_idx_i,
   output logic                     all_done_o,
   output logic [BYTE_W-1:0]        rd_byte_o
);
   logic [LANES-1:0]        seen_q;
   logic [LANES*BYTE_W-1:0] raw_q;
   logic [LANES*BYTE_W-1:0] deinter;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
      end else if (arm_i) begin
         seen_q <= '0;
      end else begin
         seen_q <= seen_q | lane_done_i;
      end
   end

   for (genvar j = 0; j < LANES; j++) begin : g_cap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            raw_q[j*BYTE_W +: BYTE_W] <= '0;
         end else if (lane_done_i[j] && !seen_q[j] && !arm_i) begin
            raw_q[j*BYTE_W +: BYTE_W] <= lane_rx_i[j*BYTE_W +: BYTE_W];
         end
      end
   end

   lss_stripe_net #(
      .LANES  (LANES),
      .BYTE_W (BYTE_W),
      .INVERSE(1'b1)
   ) u_inv (
      .din (raw_q),
      .dout(deinter)
   );

   assign all_done_o = &seen_q;

   always_comb begin
      rd_byte_o = raw_q[BYTE_W-1:0];
      if (striped_i) begin
         for (int j = 0; j < LANES; j++) begin
            if (rd_idx_i == IDX_W'(j)) begin
               rd_byte_o = deinter[j*BYTE_W +: BYTE_W];
            end
         end
      end
   end

endmodule

// File: rtl/lss_ctrl.sv
module lss_ctrl
   import lss_pkg::*;
#(
   parameter int LANES = 2,
   parameter int LVL_W = 6,
   parameter int IDX_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             striped_mode_i,
   input  logic             linear_mode_i,
   input  logic             clr_flags_i,
   input  logic [LVL_W-1:0] tx_level_i,
   input  logic             rx_full_i,
   input  logic             all_done_i,
   output logic             tx_pop_o,
   output logic             buf_wr_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             launch_o,
   output logic             rx_push_o,
   output logic             striped_q_o,
   output logic             busy_o,
   output logic             tx_underflow_o,
   output logic             rx_overflow_o
);
   localparam logic [LVL_W-1:0] NEED_STRIPED = LVL_W'(LANES);
   localparam logic [LVL_W-1:0] NEED_SINGLE  = LVL_W'(1);
   localparam logic [IDX_W-1:0] LAST_STRIPED = IDX_W'(LANES - 1);

   seq_state_e       state_q, state_d;
   logic [IDX_W-1:0] cnt_q, cnt_d;
   logic             striped_q, striped_d;
   logic             uf_q, ov_q;
   logic             uf_set, ov_set;
   logic             last_elem;
   logic             can_start;

   assign last_elem = (cnt_q == (striped_q ? LAST_STRIPED : '0));
   assign can_start = tx_level_i >= (striped_mode_i ? NEED_STRIPED : NEED_SINGLE);

   always_comb begin
      state_d   = state_q;
      cnt_d     = cnt_q;
      striped_d = striped_q;
      tx_pop_o  = 1'b0;
      buf_wr_o  = 1'b0;
      launch_o  = 1'b0;
      rx_push_o = 1'b0;
      uf_set    = 1'b0;
      ov_set    = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (flush_i) state_d = ST_CHECK;
         end
         ST_CHECK: begin
            if (can_start) begin
               striped_d = striped_mode_i;
               cnt_d     = '0;
               state_d   = ST_POP;
            end else begin
               uf_set  = !linear_mode_i;
               state_d = ST_IDLE;
            end
         end
         ST_POP: begin
            tx_pop_o = 1'b1;
            buf_wr_o = 1'b1;
            if (last_elem) begin
               state_d = ST_LAUNCH;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_LAUNCH: begin
            launch_o = 1'b1;
            state_d  = ST_WAIT;
         end
         ST_WAIT: begin
            if (all_done_i) begin
               cnt_d   = '0;
               state_d = ST_PUSH;
            end
         end
         ST_PUSH: begin
            if (rx_full_i) ov_set    = 1'b1;
            else           rx_push_o = 1'b1;
            if (last_elem) begin
               state_d = ST_CHECK;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         striped_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         cnt_q     <= cnt_d;
         striped_q <= striped_d;
      end
   end

   // Sticky flags: a set in the same cycle as a clear wins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uf_q <= 1'b0;
         ov_q <= 1'b0;
      end else begin
         uf_q <= uf_set | (uf_q & ~clr_flags_i);
         ov_q <= ov_set | (ov_q & ~clr_flags_i);
      end
   end

   assign idx_o          = cnt_q;
   assign striped_q_o    = striped_q;
   assign busy_o         = (state_q != ST_IDLE);
   assign tx_underflow_o = uf_q;
   assign rx_overflow_o  = ov_q;

endmodule

// File: rtl/lane_stripe_seq.sv
module lane_stripe_seq #(
   parameter int LANES  = 2,
   parameter int BYTE_W = 8,
   parameter int LVL_W  = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush_i,
   input  logic                     striped_mode_i,
   input  logic                     linear_mode_i,
   input  logic                     clr_flags_i,
   input  logic [LVL_W-1:0]         tx_level_i,
   input  logic [BYTE_W-1:0]        tx_data_i,
   output logic                     tx_pop_o,
   input  logic                     rx_full_i,
   output logic                     rx_push_o,
   output logic [BYTE_W-1:0]        rx_data_o,
   output logic [LANES-1:0]         lane_req_o,
   output logic [LANES*BYTE_W-1:0]  lane_tx_o,
   input  logic [LANES-1:0]         lane_done_i,
   input  logic [LANES*BYTE_W-1:0]  lane_rx_i,
   output logic                     busy_o,
   output logic                     tx_underflow_o,
   output logic                     rx_overflow_o
);
   localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

   if (LANES < 1) begin : g_bad_lanes
      $error("lane_stripe_seq: LANES must be at least 1");
   end
   if (BYTE_W < 1) begin : g_bad_width
      $error("lane_stripe_seq: BYTE_W must be at least 1");
   end
   if (LANES > (2 ** LVL_W) - 1) begin : g_bad_level
      $error("lane_stripe_seq: LVL_W too narrow to express a full group");
   end

   logic             buf_wr;
   logic [IDX_W-1:0] idx;
   logic             launch;
   logic             striped_q;
   logic             all_done;

   lss_ctrl #(
      .LANES(LANES),
      .LVL_W(LVL_W),
      .IDX_W(IDX_W)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .flush_i       (flush_i),
      .striped_mode_i(striped_mode_i),
      .linear_mode_i (linear_mode_i),
      .clr_flags_i   (clr_flags_i),
      .tx_level_i    (tx_level_i),
      .rx_full_i     (rx_full_i),
      .all_done_i    (all_done),
      .tx_pop_o      (tx_pop_o),
      .buf_wr_o      (buf_wr),
      .idx_o         (idx),
      .launch_o      (launch),
      .rx_push_o     (rx_push_o),
      .striped_q_o   (striped_q),
      .busy_o        (busy_o),
      .tx_underflow_o(tx_underflow_o),
      .rx_overflow_o (rx_overflow_o)
   );

   lss_tx_gather #(
      .LANES (LANES),
      .BYTE_W(BYTE_W),
      .IDX_W (IDX_W)
   ) u_gather (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (buf_wr),
      .wr_idx_i (idx),
      .data_i   (tx_data_i),
      .striped_i(striped_q),
      .lane_tx_o(lane_tx_o)
   );

   lss_rx_collect #(
      .LANES (LANES),
      .BYTE_W(BYTE_W),
      .IDX_W (IDX_W)
   ) u_collect (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm_i      (launch),
      .lane_done_i(lane_done_i),
      .lane_rx_i  (lane_rx_i),
      .striped_i  (striped_q),
      .rd_idx_i   (idx),
      .all_done_o (all_done),
      .rd_byte_o  (rx_data_o)
   );

   assign lane_req_o = {LANES{launch}};

endmodule

// File: rtl/lane_stripe_seq_chk.sv
module lane_stripe_seq_chk #(
   parameter int LANES  = 2,
   parameter int BYTE_W = 8,
   parameter int LVL_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              linear_mode_i,
   input logic              clr_flags_i,
   input logic [LVL_W-1:0]  tx_level_i,
   input logic              tx_pop_o,
   input logic              rx_full_i,
   input logic              rx_push_o,
   input logic [LANES-1:0]  lane_req_o,
   input logic              busy_o,
   input logic              tx_underflow_o,
   input logic              rx_overflow_o
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !(tx_pop_o || rx_push_o || (|lane_req_o))) else $error("idle activity"); // R1
   AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop_o |-> (tx_level_i != '0)) else $error("pop from empty queue"); // R6
   AST_UF_NOT_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_underflow_o) |-> !$past(linear_mode_i)) else $error("underflow in linear mode"); // R7
   AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push_o |-> !rx_full_i) else $error("push into full queue"); // R8
   AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_underflow_o && !clr_flags_i) |=> tx_underflow_o) else $error("underflow lost"); // R9
   AST_OV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_overflow_o && !clr_flags_i) |=> rx_overflow_o) else $error("overflow lost"); // R9
   AST_LANES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      (|lane_req_o) |-> (&lane_req_o)) else $error("lanes launched apart"); // R10
   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (|lane_req_o) |=> !(|lane_req_o)) else $error("request longer than a cycle"); // R10
   AST_POP_PUSH_APART: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_pop_o && rx_push_o)) else $error("pop and push together"); // R11
endmodule

bind lane_stripe_seq lane_stripe_seq_chk #(
   .LANES (LANES),
   .BYTE_W(BYTE_W),
   .LVL_W (LVL_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .linear_mode_i (linear_mode_i),
   .clr_flags_i   (clr_flags_i),
   .tx_level_i    (tx_level_i),
   .tx_pop_o      (tx_pop_o),
   .rx_full_i     (rx_full_i),
   .rx_push_o     (rx_push_o),
   .lane_req_o    (lane_req_o),
   .busy_o        (busy_o),
   .tx_underflow_o(tx_underflow_o),
   .rx_overflow_o (rx_overflow_o)
);

// File: tb/lane_stripe_seq_tb.sv
`timescale 1ns/1ps
module lane_stripe_seq_tb;
   localparam int LANES  = 2;
   localparam int BYTE_W = 8;
   localparam int LVL_W  = 6;
   localparam int FW     = LANES * BYTE_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush_i = 1'b0, striped_mode_i = 1'b0, linear_mode_i = 1'b0, clr_flags_i = 1'b0;
   logic rx_full_i = 1'b0;
   logic [LVL_W-1:0] tx_level_i;
   logic [BYTE_W-1:0] tx_data_i;
   logic tx_pop_o, rx_push_o, busy_o, tx_underflow_o, rx_overflow_o;
   logic [BYTE_W-1:0] rx_data_o;
   logic [LANES-1:0] lane_req_o;
   logic [FW-1:0] lane_tx_o;
   logic [LANES-1:0] lane_done_i;
   logic [FW-1:0] lane_rx_i;

   always #4 clk = ~clk;   // 125 MHz

   lane_stripe_seq #(.LANES(LANES), .BYTE_W(BYTE_W), .LVL_W(LVL_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .striped_mode_i(striped_mode_i),
      .linear_mode_i(linear_mode_i), .clr_flags_i(clr_flags_i), .tx_level_i(tx_level_i),
      .tx_data_i(tx_data_i), .tx_pop_o(tx_pop_o), .rx_full_i(rx_full_i), .rx_push_o(rx_push_o),
      .rx_data_o(rx_data_o), .lane_req_o(lane_req_o), .lane_tx_o(lane_tx_o),
      .lane_done_i(lane_done_i), .lane_rx_i(lane_rx_i), .busy_o(busy_o),
      .tx_underflow_o(tx_underflow_o), .rx_overflow_o(rx_overflow_o));

   int n_chk = 0, n_err = 0;

   // Transmit queue model (show-ahead)
   logic [7:0] txmem [64];
   int tx_wr = 0, tx_rd = 0;
   assign tx_level_i = LVL_W'(tx_wr - tx_rd);
   assign tx_data_i  = txmem[tx_rd % 64];
   always @(posedge clk) if (tx_pop_o) tx_rd <= tx_rd + 1;

   // Receive log
   logic [7:0] rx_log [64];
   int rx_n = 0;
   always @(posedge clk) if (rx_push_o) begin
      rx_log[rx_n % 64] <= rx_data_o;
      rx_n <= rx_n + 1;
   end

   // Lane models
   int lane_delay [LANES];
   logic [7:0] lane_xor [LANES];
   int lcnt [LANES];
   logic [7:0] lcap [LANES];
   logic [7:0] lane_log [LANES][16];
   int lane_n [LANES];
   logic [LANES-1:0] pend = '0;
   int viol_push = 0, viol_req = 0;
   initial for (int j = 0; j < LANES; j++) begin
      lcnt[j] = 0; lane_n[j] = 0; lcap[j] = '0;
      lane_delay[j] = 2; lane_xor[j] = '0;
   end
   initial begin lane_done_i = '0; lane_rx_i = '0; end

   always @(posedge clk) begin
      if (rx_push_o && (|pend)) viol_push <= viol_push + 1;
      if ((|lane_req_o) && !(&lane_req_o)) viol_req <= viol_req + 1;
      for (int j = 0; j < LANES; j++) begin
         lane_done_i[j] <= 1'b0;
         if (lane_req_o[j]) begin
            lcnt[j] <= lane_delay[j];
            lcap[j] <= lane_tx_o[j*8 +: 8];
            lane_log[j][lane_n[j] % 16] <= lane_tx_o[j*8 +: 8];
            lane_n[j] <= lane_n[j] + 1;
            pend[j] <= 1'b1;
         end else if (lcnt[j] == 1) begin
            lcnt[j] <= 0;
            lane_done_i[j] <= 1'b1;
            lane_rx_i[j*8 +: 8] <= lcap[j] ^ lane_xor[j];
            pend[j] <= 1'b0;
         end else if (lcnt[j] > 1) begin
            lcnt[j] <= lcnt[j] - 1;
         end
      end
   end

   // Reference mappings written from R2 / R3
   function automatic logic [FW-1:0] ref_stripe(input logic [FW-1:0] elems);
      logic [FW-1:0] r = '0;
      for (int j = 0; j < LANES; j++)
         for (int b = 0; b < 8; b++) r[b*LANES + j] = elems[j*8 + b];
      return r;
   endfunction
   function automatic logic [FW-1:0] ref_unstripe(input logic [FW-1:0] lanes);
      logic [FW-1:0] r = '0;
      for (int j = 0; j < LANES; j++)
         for (int b = 0; b < 8; b++) r[j*8 + b] = lanes[b*LANES + j];
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic load(input logic [7:0] v);
      txmem[tx_wr % 64] = v;
      tx_wr++;
   endtask

   task automatic run_flush();
      @(negedge clk) flush_i = 1'b1;
      @(negedge clk) flush_i = 1'b0;
      for (int i = 0; i < 500 && busy_o; i++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_clear();
      @(negedge clk) clr_flags_i = 1'b1;
      @(negedge clk) clr_flags_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 busy", busy_o, 0);
      chk("R1 strobes", {tx_pop_o, rx_push_o, lane_req_o}, 0);
      chk("R1 flags", {tx_underflow_o, rx_overflow_o}, 0);
   endtask

   task automatic t_striped_basic();
      int rb = rx_n, l0 = lane_n[0], l1 = lane_n[1];
      logic [FW-1:0] exp_tx = ref_stripe(16'h00FF);
      striped_mode_i = 1'b1; lane_xor[0] = 0; lane_xor[1] = 0;
      load(8'hFF); load(8'h00);
      run_flush();
      chk("R2 lane0 byte", lane_log[0][l0 % 16], exp_tx[7:0]);
      chk("R2 lane1 byte", lane_log[1][l1 % 16], exp_tx[15:8]);
      chk("R3 push count", rx_n - rb, 2);
      chk("R3 elem0", rx_log[rb % 64], 8'hFF);
      chk("R3 elem1", rx_log[(rb + 1) % 64], 8'h00);
      chk("R7 underflow set", tx_underflow_o, 1);
      pulse_clear();
      @(negedge clk);
      chk("R9 clear", tx_underflow_o, 0);
   endtask

   task automatic t_unstripe();
      int rb = rx_n;
      logic [FW-1:0] lanes_back = ref_stripe(16'h3C0F) ^ 16'hFF00;
      logic [FW-1:0] exp_rx = ref_unstripe(lanes_back);
      striped_mode_i = 1'b1; lane_xor[0] = 8'h00; lane_xor[1] = 8'hFF;
      load(8'h0F); load(8'h3C);
      run_flush();
      chk("R3 unstripe elem0", rx_log[rb % 64], exp_rx[7:0]);
      chk("R3 unstripe elem1", rx_log[(rb + 1) % 64], exp_rx[15:8]);
      lane_xor[1] = 8'h00;
      pulse_clear();
   endtask

   task automatic t_replicated();
      int rb = rx_n, l0 = lane_n[0], l1 = lane_n[1];
      striped_mode_i = 1'b0; lane_xor[0] = 8'h00; lane_xor[1] = 8'hFF;
      load(8'hA5); load(8'h3C);
      run_flush();
      chk("R4 lane0 grp0", lane_log[0][l0 % 16], 8'hA5);
      chk("R4 lane1 grp0", lane_log[1][l1 % 16], 8'hA5);
      chk("R11 lane1 grp1", lane_log[1][(l1 + 1) % 16], 8'h3C);
      chk("R5 push count", rx_n - rb, 2);
      chk("R5 lane0 data", {rx_log[rb % 64], rx_log[(rb + 1) % 64]}, 16'hA53C);
      lane_xor[1] = 8'h00;
      pulse_clear();
   endtask

   task automatic t_partial();
      int rb = rx_n;
      striped_mode_i = 1'b1;
      load(8'h11); load(8'h22); load(8'h33);
      run_flush();
      chk("R6 leftover level", tx_level_i, 1);
      chk("R6 push count", rx_n - rb, 2);
      chk("R6 underflow", tx_underflow_o, 1);
      striped_mode_i = 1'b0;
      run_flush();
      chk("R11 drain byte", rx_log[(rb + 2) % 64], 8'h33);
      chk("R11 queue empty", tx_level_i, 0);
      pulse_clear();
   endtask

   task automatic t_linear();
      linear_mode_i = 1'b1;
      run_flush();
      chk("R7 linear no underflow", tx_underflow_o, 0);
      chk("R7 back to idle", busy_o, 0);
      linear_mode_i = 1'b0;
   endtask

   task automatic t_overflow();
      int rb = rx_n;
      striped_mode_i = 1'b1; rx_full_i = 1'b1;
      load(8'h5A); load(8'hA5);
      run_flush();
      chk("R8 no push", rx_n - rb, 0);
      chk("R8 overflow set", rx_overflow_o, 1);
      rx_full_i = 1'b0;
      repeat (4) @(negedge clk);
      chk("R9 overflow sticky", rx_overflow_o, 1);
      pulse_clear();
      @(negedge clk);
      chk("R9 overflow cleared", rx_overflow_o, 0);
   endtask

   task automatic t_set_vs_clear();
      bit seen = 0;
      striped_mode_i = 1'b1; rx_full_i = 1'b1;
      load(8'h01); load(8'h02);
      @(negedge clk) begin clr_flags_i = 1'b1; flush_i = 1'b1; end
      @(negedge clk) flush_i = 1'b0;
      for (int i = 0; i < 500 && busy_o; i++) begin
         if (rx_overflow_o) seen = 1;
         @(negedge clk);
      end
      if (rx_overflow_o) seen = 1;
      chk("R9 set wins over clear", seen, 1);
      repeat (2) @(negedge clk);
      chk("R9 cleared after group", rx_overflow_o, 0);
      clr_flags_i = 1'b0; rx_full_i = 1'b0;
      pulse_clear();
   endtask

   task automatic t_lane_wait();
      int rb = rx_n;
      int vp = viol_push, vr = viol_req;
      striped_mode_i = 1'b1;
      lane_delay[0] = 1; lane_delay[1] = 9;
      load(8'hC3); load(8'h7E);
      run_flush();
      chk("R10 no early push", viol_push - vp, 0);
      chk("R10 lanes together", viol_req - vr, 0);
      chk("R10 data after wait", {rx_log[rb % 64], rx_log[(rb + 1) % 64]}, 16'hC37E);
      lane_delay[0] = 2; lane_delay[1] = 2;
      pulse_clear();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_striped_basic();
      t_unstripe();
      t_replicated();
      t_partial();
      t_linear();
      t_overflow();
      t_set_vs_clear();
      t_lane_wait();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule